// File: doc/BRIEF.md
# Byte-Wide DMA Word Packer

This engine copies a block of words between an 8-bit external byte memory and on-chip program or data memory. Each on-chip word is built from, or broken into, one, two or three consecutive byte accesses, depending on a two-bit format code. Multi-byte words travel most significant byte first, at rising byte addresses. The 22-bit byte address is formed from an 8-bit page above a 14-bit offset. The internal word address rises by one per word.

Software sets the format, direction, internal start address, external offset and page, a wait-state count and a context-hold option. It then writes a nonzero word count, which starts the run. The engine samples every setting in that cycle. The live count can be read back while the run is in progress. The processor's own external accesses pre-empt the engine's byte accesses. At the end of a run a single-cycle interrupt is raised. When the context-hold option is set, the core is held for the whole run and is then told to restart at address 0.

Top module: `bytepack_dma`

## Requirements
- R1: The format code selects the packing. 2'b00 is a 24-bit program word of 3 bytes. 2'b01 is a 16-bit data word of 2 bytes. 2'b10 is one byte placed in data bits [15:8]. 2'b11 is one byte placed in data bits [7:0]. Multi-byte words are ordered most significant byte first, at ascending byte addresses.
- R2: In both one-byte formats, every word bit not taken by the byte is driven as zero. In all data formats, bits [23:16] of the internal write word are zero.
- R3: The byte address `bm_addr` is {page, offset} and rises by one after each byte access. A carry out of the 14-bit offset increments the page.
- R4: A write of a nonzero value to the count while the engine is idle starts a run. A write of zero, or any count write during a run, has no effect.
- R5: `cnt_q` holds the number of words still to move. It decrements by one as each word completes.
- R6: When the count reaches zero the engine returns to idle and `irq` is high for exactly one cycle, in the same cycle that `busy` falls.
- R7: Each byte access lasts (wait + 1) granted cycles, where wait is the 3-bit wait field. Moving each word to or from internal memory takes one more cycle. Without contention, a run of W words of N bytes keeps `busy` high for W*(N*(wait+1)+1) cycles.
- R8: Each internal word access uses `im_req` for one cycle. `im_addr` starts at the programmed internal address and rises by one per word. `im_pm` is high only for format 2'b00.
- R9: `bm_req` is never high in a cycle where `cpu_ext_req` is high. A pre-empted access resumes, and the data is unchanged.
- R10: With the context-hold option at 1, `core_hold` equals `busy` for the whole run, and `core_restart` pulses once as the run ends. With the option at 0, neither output is asserted.
- R11: Direction 0 moves data from byte memory to internal memory. Direction 1 moves data from internal memory to byte memory, with `bm_we` high during its byte accesses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_fmt | input | 2 | Word format code |
| cfg_dir | input | 1 | 0: byte to internal, 1: internal to byte |
| cfg_iaddr | input | IAW | Internal start address |
| cfg_eaddr | input | EAW | External start offset |
| cfg_page | input | PGW | External start page |
| cfg_wait | input | WSW | Wait states per byte access |
| cfg_ctx | input | 1 | Hold core during the run, then restart it |
| cnt_we | input | 1 | Word count write strobe |
| cnt_wdata | input | CNTW | Word count value |
| cnt_q | output | CNTW | Live remaining word count |
| busy | output | 1 | Run in progress |
| irq | output | 1 | One-cycle completion pulse |
| cpu_ext_req | input | 1 | Processor external access, has priority |
| bm_req | output | 1 | Byte memory access active |
| bm_we | output | 1 | Byte memory write |
| bm_addr | output | PGW+EAW | Byte address {page, offset} |
| bm_wdata | output | 8 | Byte write data |
| bm_rdata | input | 8 | Byte read data |
| im_req | output | 1 | Internal memory access |
| im_we | output | 1 | Internal memory write |
| im_pm | output | 1 | Access targets program memory |
| im_addr | output | IAW | Internal word address |
| im_wdata | output | 24 | Internal write word |
| im_rdata | input | 24 | Internal read word, valid in the same cycle |
| core_hold | output | 1 | Core stalled |
| core_restart | output | 1 | Core restart at address 0 pulse |

## Verification
The bench uses the default widths: a 14-bit offset, an 8-bit page, a 14-bit count and a 3-bit wait field. It sweeps all four formats, both directions and wait counts of 0, 2 and 7. Every run starts at offset 0x3FFD of page 5, so each run crosses into page 6 and the page carry is exercised in every format. Further runs with processor contention and with count writes during a run cover the arbitration and ignore rules. The context-hold option is checked in both of its states.

// File: rtl/bpk_pkg.sv
package bpk_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_FETCH, ST_BYTE, ST_STORE} bpk_state_e;

  localparam logic [1:0] FMT_PM24  = 2'b00;
  localparam logic [1:0] FMT_DM16  = 2'b01;
  localparam logic [1:0] FMT_DM8HI = 2'b10;
  localparam logic [1:0] FMT_DM8LO = 2'b11;

  // number of byte accesses per internal word
  function automatic logic [1:0] bytes_per_word(input logic [1:0] f);
    case (f)
      FMT_PM24: return 2'd3;
      FMT_DM16: return 2'd2;
      default:  return 2'd1;
    endcase
  endfunction
endpackage

// File: rtl/bpk_addr_gen.sv
module bpk_addr_gen #(
  parameter int EAW = 14,
  parameter int PGW = 8,
  parameter int IAW = 14
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load,
  input  logic [EAW-1:0]     ld_ext,
  input  logic [PGW-1:0]     ld_page,
  input  logic [IAW-1:0]     ld_int,
  input  logic               step_ext,
  input  logic               step_int,
  output logic [PGW+EAW-1:0] ext_addr,
  output logic [IAW-1:0]     int_addr
);
  localparam int XW = PGW + EAW;
  localparam logic [XW-1:0]  XONE = {{(XW-1){1'b0}}, 1'b1};
  localparam logic [IAW-1:0] IONE = {{(IAW-1){1'b0}}, 1'b1};

  logic [XW-1:0]  ext_q, ext_d;
  logic [IAW-1:0] int_q, int_d;

  // page and offset count as one value so the offset carry reaches the page
  always_comb begin
    ext_d = ext_q;
    int_d = int_q;
    if (load) begin
      ext_d = {ld_page, ld_ext};
      int_d = ld_int;
    end else begin
      if (step_ext) ext_d = ext_q + XONE;
      if (step_int) int_d = int_q + IONE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ext_q <= '0;
      int_q <= '0;
    end else begin
      ext_q <= ext_d;
      int_q <= int_d;
    end
  end

  assign ext_addr = ext_q;
  assign int_addr = int_q;
endmodule

// File: rtl/bpk_packer.sv
module bpk_packer
  import bpk_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic [1:0]  fmt,
  input  logic        load,
  input  logic [23:0] load_word,
  input  logic        shift,
  input  logic [7:0]  byte_in,
  output logic [7:0]  byte_out,
  output logic [23:0] word_out
);
  logic [23:0] sh_q, sh_d;

  // one shift register serves both directions: the top byte leaves, the new byte enters at the bottom
  always_comb begin
    sh_d = sh_q;
    if (load) begin
      case (fmt)
        FMT_PM24:  sh_d = load_word;
        FMT_DM16:  sh_d = {load_word[15:0], 8'h00};
        FMT_DM8HI: sh_d = {load_word[15:8], 16'h0000};
        default:   sh_d = {load_word[7:0], 16'h0000};
      endcase
    end else if (shift) begin
      sh_d = {sh_q[15:0], byte_in};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_d;
  end

  always_comb begin
    case (fmt)
      FMT_PM24:  word_out = sh_q;
      FMT_DM16:  word_out = {8'h00, sh_q[15:0]};
      FMT_DM8HI: word_out = {8'h00, sh_q[7:0], 8'h00};
      default:   word_out = {16'h0000, sh_q[7:0]};
    endcase
  end

  assign byte_out = sh_q[23:16];
endmodule

// File: rtl/bytepack_dma.sv
module bytepack_dma
  import bpk_pkg::*;
#(
  parameter int EAW  = 14,
  parameter int PGW  = 8,
  parameter int IAW  = 14,
  parameter int CNTW = 14,
  parameter int WSW  = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [1:0]         cfg_fmt,
  input  logic               cfg_dir,
  input  logic [IAW-1:0]     cfg_iaddr,
  input  logic [EAW-1:0]     cfg_eaddr,
  input  logic [PGW-1:0]     cfg_page,
  input  logic [WSW-1:0]     cfg_wait,
  input  logic               cfg_ctx,
  input  logic               cnt_we,
  input  logic [CNTW-1:0]    cnt_wdata,
  output logic [CNTW-1:0]    cnt_q,
  output logic               busy,
  output logic               irq,
  input  logic               cpu_ext_req,
  output logic               bm_req,
  output logic               bm_we,
  output logic [PGW+EAW-1:0] bm_addr,
  output logic [7:0]         bm_wdata,
  input  logic [7:0]         bm_rdata,
  output logic               im_req,
  output logic               im_we,
  output logic               im_pm,
  output logic [IAW-1:0]     im_addr,
  output logic [23:0]        im_wdata,
  input  logic [23:0]        im_rdata,
  output logic               core_hold,
  output logic               core_restart
);
  localparam logic [CNTW-1:0] CNT_ONE = {{(CNTW-1){1'b0}}, 1'b1};
  localparam logic [WSW-1:0]  WS_ONE  = {{(WSW-1){1'b0}}, 1'b1};

  bpk_state_e st_q, st_d;
  logic [1:0]      fmt_q;
  logic            dir_q, ctx_q;
  logic [WSW-1:0]  wait_q, ws_q, ws_d;
  logic [1:0]      left_q, left_d;
  logic [CNTW-1:0] cnt_r, cnt_d;
  logic            irq_q, rst_pulse_q;

  logic start, grant, byte_done, last_byte, word_done, finish;

  always_comb begin
    start     = (st_q == ST_IDLE) && cnt_we && (cnt_wdata != '0);
    grant     = (st_q == ST_BYTE) && !cpu_ext_req;
    byte_done = grant && (ws_q == wait_q);
    last_byte = byte_done && (left_q == 2'd1);
    word_done = (st_q == ST_STORE) || (last_byte && dir_q);
    finish    = word_done && (cnt_r == CNT_ONE);
  end

  // next state
  always_comb begin
    st_d = st_q;
    case (st_q)
      ST_IDLE:  if (start) st_d = cfg_dir ? ST_FETCH : ST_BYTE;
      ST_FETCH: st_d = ST_BYTE;
      ST_BYTE:  if (last_byte) begin
                  if (!dir_q)     st_d = ST_STORE;
                  else if (finish) st_d = ST_IDLE;
                  else            st_d = ST_FETCH;
                end
      ST_STORE: st_d = finish ? ST_IDLE : ST_BYTE;
      default:  st_d = ST_IDLE;
    endcase
  end

  // counters: wait holds while pre-empted, byte index reloads per word
  always_comb begin
    ws_d   = ws_q;
    left_d = left_q;
    cnt_d  = cnt_r;
    if (start) begin
      ws_d   = '0;
      left_d = bytes_per_word(cfg_fmt);
      cnt_d  = cnt_wdata;
    end else begin
      if (grant)     ws_d = byte_done ? '0 : ws_q + WS_ONE;
      if (byte_done) left_d = (left_q == 2'd1) ? bytes_per_word(fmt_q) : left_q - 2'd1;
      if (word_done) cnt_d = cnt_r - CNT_ONE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q        <= ST_IDLE;
      ws_q        <= '0;
      left_q      <= '0;
      cnt_r       <= '0;
      irq_q       <= 1'b0;
      rst_pulse_q <= 1'b0;
    end else begin
      st_q        <= st_d;
      ws_q        <= ws_d;
      left_q      <= left_d;
      cnt_r       <= cnt_d;
      irq_q       <= finish;
      rst_pulse_q <= finish && ctx_q;
    end
  end

  // settings captured once per run
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fmt_q  <= FMT_PM24;
      dir_q  <= 1'b0;
      ctx_q  <= 1'b0;
      wait_q <= '0;
    end else if (start) begin
      fmt_q  <= cfg_fmt;
      dir_q  <= cfg_dir;
      ctx_q  <= cfg_ctx;
      wait_q <= cfg_wait;
    end
  end

  bpk_addr_gen #(.EAW(EAW), .PGW(PGW), .IAW(IAW)) u_addr (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (start),
    .ld_ext   (cfg_eaddr),
    .ld_page  (cfg_page),
    .ld_int   (cfg_iaddr),
    .step_ext (byte_done),
    .step_int (word_done),
    .ext_addr (bm_addr),
    .int_addr (im_addr)
  );

  bpk_packer u_pack (
    .clk       (clk),
    .rst_n     (rst_n),
    .fmt       (fmt_q),
    .load      (st_q == ST_FETCH),
    .load_word (im_rdata),
    .shift     (byte_done),
    .byte_in   (bm_rdata),
    .byte_out  (bm_wdata),
    .word_out  (im_wdata)
  );

  assign bm_req       = grant;
  assign bm_we        = grant && dir_q;
  assign im_req       = (st_q == ST_FETCH) || (st_q == ST_STORE);
  assign im_we        = (st_q == ST_STORE);
  assign im_pm        = (fmt_q == FMT_PM24);
  assign busy         = (st_q != ST_IDLE);
  assign cnt_q        = cnt_r;
  assign irq          = irq_q;
  assign core_hold    = busy && ctx_q;
  assign core_restart = rst_pulse_q;
endmodule

// File: rtl/bpk_chk.sv
module bpk_chk #(
  parameter int CNTW = 14
) (
  input logic            clk,
  input logic            rst_n,
  input logic            cpu_ext_req,
  input logic            bm_req,
  input logic            bm_we,
  input logic            busy,
  input logic            irq,
  input logic [CNTW-1:0] cnt_q,
  input logic            core_hold,
  input logic            core_restart,
  input logic            im_we,
  input logic            im_pm,
  input logic [23:0]     im_wdata
);
  assert_cpu_first_R9: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_ext_req |-> !bm_req) else $error("processor access overlapped engine byte access");

  assert_irq_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq) else $error("completion pulse longer than one cycle");

  assert_irq_at_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (cnt_q == '0 && !busy)) else $error("completion pulse while words remain");

  assert_count_falls_R5: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> (cnt_q <= $past(cnt_q))) else $error("count rose during a run");

  assert_hold_in_run_R10: assert property (@(posedge clk) disable iff (!rst_n)
    core_hold |-> busy) else $error("core held outside a run");

  assert_restart_end_R10: assert property (@(posedge clk) disable iff (!rst_n)
    core_restart |-> irq) else $error("restart away from run end");

  assert_zero_fill_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (im_we && !im_pm) |-> (im_wdata[23:16] == 8'h00)) else $error("data word upper bits not zero");

  assert_write_in_access_R11: assert property (@(posedge clk) disable iff (!rst_n)
    bm_we |-> bm_req) else $error("byte write outside an access");
endmodule

bind bytepack_dma bpk_chk #(.CNTW(CNTW)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .cpu_ext_req  (cpu_ext_req),
  .bm_req       (bm_req),
  .bm_we        (bm_we),
  .busy         (busy),
  .irq          (irq),
  .cnt_q        (cnt_q),
  .core_hold    (core_hold),
  .core_restart (core_restart),
  .im_we        (im_we),
  .im_pm        (im_pm),
  .im_wdata     (im_wdata)
);

// File: tb/sim_bytepack_dma.sv
module sim_bytepack_dma;
  localparam int CLK_PERIOD = 10;
  localparam logic [13:0] EA0 = 14'h3FFD;
  localparam logic [7:0]  PG0 = 8'h05;
  localparam logic [13:0] IA0 = 14'd10;

  logic clk = 1'b0;
  logic rst_n;
  logic [1:0] cfg_fmt;
  logic cfg_dir, cfg_ctx, cnt_we, cpu_ext_req;
  logic [13:0] cfg_iaddr, cfg_eaddr, cnt_wdata, cnt_q;
  logic [7:0] cfg_page, bm_wdata, bm_rdata;
  logic [2:0] cfg_wait;
  logic busy, irq, bm_req, bm_we, im_req, im_we, im_pm, core_hold, core_restart;
  logic [21:0] bm_addr;
  logic [13:0] im_addr;
  logic [23:0] im_wdata, im_rdata;

  logic [23:0] imem [0:63];
  logic [7:0]  bwr [logic [21:0]];

  int checks = 0, errors = 0;
  int busy_cyc, irq_cnt, rst_cnt, hold_err, overlap, pm_err, cnt_err, exp_cnt;
  logic contend = 1'b0;
  logic run_fmt_pm;

  always #(CLK_PERIOD/2) clk = ~clk;

  bytepack_dma u0 (.*);

  function automatic logic [7:0] bfun(input logic [21:0] a);
    return a[7:0] ^ a[21:14] ^ {a[13:8], 2'b11};
  endfunction

  function automatic logic [23:0] ipat(input int i);
    return 24'hA51C00 ^ (24'(i) * 24'h010203);
  endfunction

  assign bm_rdata = bfun(bm_addr);
  assign im_rdata = imem[im_addr[5:0]];

  // monitor and memory write side
  always @(negedge clk) begin
    if (busy) busy_cyc++;
    if (irq) irq_cnt++;
    if (core_restart) rst_cnt++;
    if (core_hold != (busy && cfg_ctx)) hold_err++;
    if (cpu_ext_req && bm_req) overlap++;
    if (im_req && (im_pm != run_fmt_pm)) pm_err++;
    if (bm_req && bm_we) bwr[bm_addr] = bm_wdata;
    if (im_req && im_we) begin
      if (cnt_q != 14'(exp_cnt)) cnt_err++;
      exp_cnt--;
      imem[im_addr[5:0]] = im_wdata;
    end
  end

  // contention driver
  initial begin
    logic [4:0] lf = 5'h13;
    cpu_ext_req = 1'b0;
    forever begin
      @(negedge clk);
      lf = {lf[3:0], lf[4] ^ lf[2]};
      cpu_ext_req = contend && lf[0];
    end
  end

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic run(input logic [1:0] fmt, input bit dir, input int w, input bit ctx,
                     input int nw, input bit cont, input bit poke);
    int n;
    logic [21:0] base;
    n = (fmt == 2'b00) ? 3 : (fmt == 2'b01) ? 2 : 1;
    base = {PG0, EA0};
    for (int i = 0; i < 64; i++) imem[i] = ipat(i);
    bwr.delete();
    @(negedge clk);
    busy_cyc = 0; irq_cnt = 0; rst_cnt = 0; hold_err = 0; overlap = 0; pm_err = 0; cnt_err = 0;
    exp_cnt = nw; run_fmt_pm = (fmt == 2'b00);
    cfg_fmt = fmt; cfg_dir = dir; cfg_wait = 3'(w); cfg_ctx = ctx;
    cfg_iaddr = IA0; cfg_eaddr = EA0; cfg_page = PG0;
    contend = cont;
    cnt_we = 1'b1; cnt_wdata = 14'(nw);
    @(negedge clk);
    cnt_we = 1'b0;
    if (poke) begin
      repeat (3) @(negedge clk);
      cnt_we = 1'b1; cnt_wdata = 14'h0100;
      @(negedge clk);
      cnt_we = 1'b0;
    end
    for (int t = 0; t < 4000 && busy; t++) @(negedge clk);
    contend = 1'b0;
    repeat (2) @(negedge clk);
    check(irq_cnt == 1, "R6", "irq pulses", irq_cnt, 1);
    check(cnt_q == 0 && !busy, "R5", "final count", int'(cnt_q), 0);
    if (!cont) check(busy_cyc == nw * (n * (w + 1) + 1), "R7", "busy cycles", busy_cyc, nw * (n * (w + 1) + 1));
    check(overlap == 0, "R9", "cpu overlap", overlap, 0);
    check(pm_err == 0, "R8", "pm flag", pm_err, 0);
    check(rst_cnt == int'(ctx) && hold_err == 0, "R10", "restart/hold", rst_cnt * 256 + hold_err, int'(ctx) * 256);
    if (!dir) check(cnt_err == 0, "R5", "live count", cnt_err, 0);
    for (int k = 0; k < nw; k++) begin
      logic [7:0] b0, b1, b2;
      logic [23:0] ew, src;
      logic [21:0] a;
      a = base + 22'(k * n);
      if (!dir) begin
        b0 = bfun(a); b1 = bfun(a + 22'd1); b2 = bfun(a + 22'd2);
        case (fmt)
          2'b00: ew = {b0, b1, b2};
          2'b01: ew = {8'h00, b0, b1};
          2'b10: ew = {8'h00, b0, 8'h00};
          default: ew = {16'h0000, b0};
        endcase
        check(imem[(int'(IA0) + k) % 64] == ew, (fmt[1] ? "R2" : "R1"), "word in (R3 R11)",
              int'(imem[(int'(IA0) + k) % 64]), int'(ew));
      end else begin
        src = ipat(int'(IA0) + k);
        for (int j = 0; j < n; j++) begin
          logic [7:0] eb, ab;
          case (fmt)
            2'b00: eb = (j == 0) ? src[23:16] : (j == 1) ? src[15:8] : src[7:0];
            2'b01: eb = (j == 0) ? src[15:8] : src[7:0];
            2'b10: eb = src[15:8];
            default: eb = src[7:0];
          endcase
          ab = bwr.exists(a + 22'(j)) ? bwr[a + 22'(j)] : 8'hxx;
          check(ab === eb, "R11", "byte out (R1 R3)", int'(ab), int'(eb));
        end
      end
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    cfg_fmt = 2'b00; cfg_dir = 1'b0; cfg_wait = '0; cfg_ctx = 1'b0;
    cfg_iaddr = '0; cfg_eaddr = '0; cfg_page = '0; cnt_we = 1'b0; cnt_wdata = '0;
    run_fmt_pm = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(!busy && !irq && cnt_q == 0 && !bm_req && !im_req && !core_hold, "R6", "reset state",
          int'({busy, irq, bm_req, im_req, core_hold}), 0);

    // R4: zero count write in idle does nothing
    irq_cnt = 0;
    cnt_we = 1'b1; cnt_wdata = '0;
    @(negedge clk);
    cnt_we = 1'b0;
    repeat (4) @(negedge clk);
    check(!busy && irq_cnt == 0 && cnt_q == 0, "R4", "zero write ignored", int'(busy) + irq_cnt, 0);

    for (int f = 0; f < 4; f++)
      for (int d = 0; d < 2; d++)
        for (int wi = 0; wi < 3; wi++)
          run(2'(f), d[0], (wi == 0) ? 0 : (wi == 1) ? 2 : 7, (f == 1), 5, 1'b0, 1'b0);

    // R9: contention in both directions
    run(2'b00, 1'b0, 1, 1'b0, 6, 1'b1, 1'b0);
    run(2'b01, 1'b1, 2, 1'b1, 6, 1'b1, 1'b0);
    // R4: count write during a run is ignored
    run(2'b00, 1'b0, 2, 1'b0, 4, 1'b0, 1'b1);
    run(2'b11, 1'b1, 3, 1'b0, 4, 1'b0, 1'b1);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule